// File: doc/BRIEF.md
# Ping-pong write path controller

This block is a synchronous slave that accepts 32-bit words from an external device and spreads them over two buffer threads, A and B, so that a long burst never stalls when one buffer fills. The external device has a single command pin. It starts a write burst by holding that pin at a fixed pattern for three sampled edges. It then presents one word per cycle while the pin is high, and ends the burst by pulling the pin low. Each word is first held in a register and written into a thread on the following cycle. The buffer side is abstract: each thread has a write strobe and a data output, and returns a watermark flag and a full flag.

The controller has two idle states, one per thread. They record where the next burst has to start. If the last buffer was left partly filled, the next burst continues in that same thread. If it was filled exactly, the next burst starts in the other thread. While a burst runs, a registered watermark from the active thread sends the next word to the other thread, so no word is lost at a buffer boundary.

States:
- `ST_IDLE_A` and `ST_IDLE_B` are the two idle states.
- `ST_ARM` means a high level has been seen.
- `ST_LEAD` means one low level has been seen.
- `ST_BURST` means a word is written on every cycle.
- `ST_CHK` decides which idle state comes next.

Transitions:
- idle→arm on a sampled high.
- arm→arm on a sampled high, and arm→lead on a sampled low.
- lead→burst on a sampled low.
- lead→idle of the same thread on a sampled high.
- burst→burst on a sampled high, and burst→check on a sampled low.
- check→idle of the other thread when the thread's full flag is sampled high, and check→idle of the same thread when it is sampled low.

Top module: `pingpong_wr_ctl`

## Requirements
- R1: While `rst` is sampled high, the next cycle has both strobes low, both data outputs zero and `cur_thr` at 0, which is the idle state of thread A.
- R2: From idle, a high on `cmd_pin` at one edge followed by lows at the next two edges starts a burst. The value on `din` at the third of those edges is the first word written, with its strobe high in the cycle that follows. Further highs before the first low keep the controller waiting.
- R3: While a thread's strobe is high, that thread's data output equals `din` as sampled at the preceding clock edge.
- R4: At most one strobe is high in any cycle, and a thread's data output is zero while its strobe is low.
- R5: After the first word, one word is written per cycle for as long as `cmd_pin` is sampled high. The first edge at which it is sampled low ends the strobes, and the `din` value at that edge is not written. One cycle without a strobe follows, then the controller is idle.
- R6: Thread index 0 is A (`wr_a`) and index 1 is B (`wr_b`). The buffer raises `buf_wm[i]` when thread i has at most one free word. A write goes to the thread other than the previous write's thread exactly when the previous cycle also carried a write and that thread's `buf_wm` bit was high at the edge between the two writes.
- R7: Every word of a burst is written exactly once and in order, including across thread switches.
- R8: `cur_thr` shows the thread of the most recent write, or the thread of the idle state. At the end of the check cycle, a high `buf_full` bit for that thread selects the other thread's idle state, and a low bit keeps the same one. A burst's first write goes to the thread of the idle state it started from.
- R9: After a high and then one low, a high sampled at the next edge abandons the sequence. The controller returns to the same idle state and writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cmd_pin | input | 1 | Single command pin from the external device |
| din | input | 32 | Word presented by the external device |
| buf_wm | input | 2 | Per-thread watermark: at most one free word |
| buf_full | input | 2 | Per-thread flag: active buffer exactly filled |
| wr_a | output | 1 | Write strobe of thread A |
| wdata_a | output | 32 | Word written to thread A |
| wr_b | output | 1 | Write strobe of thread B |
| wdata_b | output | 32 | Word written to thread B |
| cur_thr | output | 1 | Thread of the latest write or of the idle state |

## Verification
The assertions check the following on every cycle:
- the strobes are never high together;
- data is zero while a strobe is low, and otherwise matches the word sampled one edge earlier;
- strobes stop right after a low is sampled during a burst;
- the first write of a burst lands on the thread shown by `cur_thr`;
- a change of thread between consecutive writes happens exactly when the previous thread's watermark was high.

Some properties are only shown by the bench's scenarios, which run against a buffer model that empties full buffers:
- the start pattern with an extended high prefix;
- the abandoned sequence;
- lossless ordering across one and several thread switches;
- the choice between the two idle states after exactly filled and partly filled buffers.

// File: rtl/ppw_pkg.sv
package ppw_pkg;

    localparam int PPW_THREADS = 2;

    typedef enum logic [2:0] {
        ST_IDLE_A,
        ST_IDLE_B,
        ST_ARM,
        ST_LEAD,
        ST_BURST,
        ST_CHK
    } ppw_state_e;

endpackage

// File: rtl/ppw_sampler.sv
module ppw_sampler
    import ppw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [DATA_W-1:0]      din,
    input  logic [PPW_THREADS-1:0] wm_in,
    output logic [DATA_W-1:0]      data_q,
    output logic [PPW_THREADS-1:0] wm_q
);

    // Bus word and watermark flags are held one cycle before use.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            wm_q   <= '0;
        end else begin
            data_q <= din;
            wm_q   <= wm_in;
        end
    end

endmodule

// File: rtl/ppw_seq.sv
module ppw_seq
    import ppw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd,
    input  logic [PPW_THREADS-1:0] wm_q,
    input  logic [PPW_THREADS-1:0] full,
    output logic                   wr_en,
    output logic                   tgt,
    output logic                   cur
);

    ppw_state_e state_q;
    ppw_state_e state_d;
    logic       cur_q;
    logic       cur_d;
    logic       wr_q;
    logic       tgt_c;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE_A;
            cur_q   <= 1'b0;
            wr_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            wr_q    <= (state_q == ST_BURST);
        end
    end

    // Thread for the write in this cycle: switch only when the previous
    // cycle wrote and that thread reported its watermark.
    always_comb begin
        tgt_c = cur_q;
        if (wr_q && wm_q[cur_q]) begin
            tgt_c = ~cur_q;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        unique case (state_q)
            ST_IDLE_A: begin
                cur_d = 1'b0;
                if (cmd) state_d = ST_ARM;
            end
            ST_IDLE_B: begin
                cur_d = 1'b1;
                if (cmd) state_d = ST_ARM;
            end
            ST_ARM: begin
                if (!cmd) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (cmd) begin
                    state_d = cur_q ? ST_IDLE_B : ST_IDLE_A;
                end else begin
                    state_d = ST_BURST;
                end
            end
            ST_BURST: begin
                cur_d   = tgt_c;
                state_d = cmd ? ST_BURST : ST_CHK;
            end
            ST_CHK: begin
                cur_d   = full[cur_q] ? ~cur_q : cur_q;
                state_d = (full[cur_q] ? ~cur_q : cur_q) ? ST_IDLE_B : ST_IDLE_A;
            end
            default: begin
                state_d = ST_IDLE_A;
                cur_d   = 1'b0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        wr_en = (state_q == ST_BURST);
        tgt   = tgt_c;
        cur   = cur_q;
    end

endmodule

// File: rtl/ppw_lane.sv
module ppw_lane #(
    parameter int DATA_W = 32,
    parameter int IDX    = 0
) (
    input  logic              wr_en,
    input  logic              tgt,
    input  logic [DATA_W-1:0] data_q,
    output logic              wr,
    output logic [DATA_W-1:0] data
);

    localparam logic SEL = (IDX != 0);

    always_comb begin
        wr   = wr_en && (tgt == SEL);
        data = wr ? data_q : '0;
    end

endmodule

// File: rtl/pingpong_wr_ctl.sv
module pingpong_wr_ctl
    import ppw_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_pin,
    input  logic [DATA_W-1:0]      din,
    input  logic [PPW_THREADS-1:0] buf_wm,
    input  logic [PPW_THREADS-1:0] buf_full,
    output logic                   wr_a,
    output logic [DATA_W-1:0]      wdata_a,
    output logic                   wr_b,
    output logic [DATA_W-1:0]      wdata_b,
    output logic                   cur_thr
);

    logic [DATA_W-1:0]      data_q;
    logic [PPW_THREADS-1:0] wm_q;
    logic                   wr_en;
    logic                   tgt;
    logic [PPW_THREADS-1:0] lane_wr;
    logic [DATA_W-1:0]      lane_data [PPW_THREADS];

    ppw_sampler #(.DATA_W(DATA_W)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .din    (din),
        .wm_in  (buf_wm),
        .data_q (data_q),
        .wm_q   (wm_q)
    );

    ppw_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .cmd   (cmd_pin),
        .wm_q  (wm_q),
        .full  (buf_full),
        .wr_en (wr_en),
        .tgt   (tgt),
        .cur   (cur_thr)
    );

    for (genvar g = 0; g < PPW_THREADS; g++) begin : g_lane
        ppw_lane #(.DATA_W(DATA_W), .IDX(g)) u_lane (
            .wr_en  (wr_en),
            .tgt    (tgt),
            .data_q (data_q),
            .wr     (lane_wr[g]),
            .data   (lane_data[g])
        );
    end

    assign wr_a    = lane_wr[0];
    assign wdata_a = lane_data[0];
    assign wr_b    = lane_wr[1];
    assign wdata_b = lane_data[1];

endmodule

// File: rtl/ppw_checker.sv
module ppw_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_pin,
    input logic [DATA_W-1:0] din,
    input logic [1:0]        buf_wm,
    input logic              wr_a,
    input logic [DATA_W-1:0] wdata_a,
    input logic              wr_b,
    input logic [DATA_W-1:0] wdata_b,
    input logic              cur_thr
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!wr_a && !wr_b && !cur_thr));

    a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
        !(wr_a && wr_b));

    a_r4_zero_a: assert property (@(posedge clk) disable iff (rst)
        !wr_a |-> (wdata_a == '0));

    a_r4_zero_b: assert property (@(posedge clk) disable iff (rst)
        !wr_b |-> (wdata_b == '0));

    a_r3_word_a: assert property (@(posedge clk) disable iff (rst)
        wr_a |-> (wdata_a == $past(din)));

    a_r3_word_b: assert property (@(posedge clk) disable iff (rst)
        wr_b |-> (wdata_b == $past(din)));

    a_r5_stop_on_low: assert property (@(posedge clk) disable iff (rst)
        ((wr_a || wr_b) && !cmd_pin) |=> !(wr_a || wr_b));

    a_r6_switch_ab_needs_wm: assert property (@(posedge clk) disable iff (rst)
        (wr_b && $past(wr_a)) |-> $past(buf_wm[0]));

    a_r6_switch_ba_needs_wm: assert property (@(posedge clk) disable iff (rst)
        (wr_a && $past(wr_b)) |-> $past(buf_wm[1]));

    a_r6_wm_a_forces_switch: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_a) && $past(buf_wm[0]) && (wr_a || wr_b)) |-> wr_b);

    a_r6_wm_b_forces_switch: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_b) && $past(buf_wm[1]) && (wr_a || wr_b)) |-> wr_a);

    a_r8_first_on_cur: assert property (@(posedge clk) disable iff (rst)
        ((wr_a || wr_b) && !$past(wr_a || wr_b)) |-> (wr_b == cur_thr));

endmodule

bind pingpong_wr_ctl ppw_checker #(.DATA_W(DATA_W)) u_ppw_checker (
    .clk     (clk),
    .rst     (rst),
    .cmd_pin (cmd_pin),
    .din     (din),
    .buf_wm  (buf_wm),
    .wr_a    (wr_a),
    .wdata_a (wdata_a),
    .wr_b    (wr_b),
    .wdata_b (wdata_b),
    .cur_thr (cur_thr)
);

// File: tb/pingpong_wr_ctl_bench.sv
`timescale 1ns/1ps
module pingpong_wr_ctl_bench;

    localparam int DW  = 32;
    localparam int CAP = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_pin = 1'b0;
    logic [DW-1:0] din = '0;
    logic [1:0]    buf_wm;
    logic [1:0]    buf_full;
    logic          wr_a, wr_b, cur_thr;
    logic [DW-1:0] wdata_a, wdata_b;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    pingpong_wr_ctl #(.DATA_W(DW)) u_pingpong_wr_ctl (
        .clk(clk), .rst(rst), .cmd_pin(cmd_pin), .din(din),
        .buf_wm(buf_wm), .buf_full(buf_full),
        .wr_a(wr_a), .wdata_a(wdata_a), .wr_b(wr_b), .wdata_b(wdata_b),
        .cur_thr(cur_thr)
    );

    always #2.5 clk = ~clk;

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Buffer model: counts strobes, empties a full buffer when not written.
    int         lvl [2] = '{0, 0};
    logic [1:0] s_wr = 2'b00;
    assign buf_wm[0]   = ((CAP - lvl[0]) <= 1);
    assign buf_wm[1]   = ((CAP - lvl[1]) <= 1);
    assign buf_full[0] = (lvl[0] == CAP);
    assign buf_full[1] = (lvl[1] == CAP);

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (rst) lvl[i] <= 0;
            else if (s_wr[i]) lvl[i] <= lvl[i] + 1;
            else if (lvl[i] == CAP) lvl[i] <= 0;
        end
    end

    // Cycle reference model
    int            ph = 0;     // 0 idle, 1 armed, 2 one low seen, 3 writing, 4 deciding
    logic          mthr = 1'b0;
    logic          mpw = 1'b0;
    logic [1:0]    mwq = 2'b00;
    logic [DW-1:0] mdq = '0;
    logic          e_wr, e_tgt;

    always_comb begin
        e_wr  = (ph == 3);
        e_tgt = (mpw && mwq[mthr]) ? ~mthr : mthr;
    end

    always @(posedge clk) begin
        if (rst) begin
            ph <= 0; mthr <= 1'b0; mpw <= 1'b0; mwq <= 2'b00; mdq <= '0;
        end else begin
            mdq <= din;
            mwq <= buf_wm;
            mpw <= (ph == 3);
            if (ph == 0) begin
                if (cmd_pin) ph <= 1;
            end else if (ph == 1) begin
                if (!cmd_pin) ph <= 2;
            end else if (ph == 2) begin
                ph <= cmd_pin ? 0 : 3;
            end else if (ph == 3) begin
                mthr <= e_tgt;
                ph   <= cmd_pin ? 3 : 4;
            end else begin
                mthr <= buf_full[mthr] ? ~mthr : mthr;
                ph   <= 0;
            end
        end
    end

    // Monitor: compare every cycle and record written words
    logic [DW-1:0] got_w[$];
    logic          got_t[$];

    always @(negedge clk) begin
        s_wr <= {wr_b, wr_a};
        if (!rst) begin
            chk("R6 wr_a", {31'b0, wr_a}, {31'b0, e_wr && !e_tgt});
            chk("R6 wr_b", {31'b0, wr_b}, {31'b0, e_wr && e_tgt});
            chk("R3 R4 wdata_a", wdata_a, (e_wr && !e_tgt) ? mdq : '0);
            chk("R3 R4 wdata_b", wdata_b, (e_wr && e_tgt) ? mdq : '0);
            chk("R8 cur_thr", {31'b0, cur_thr}, {31'b0, mthr});
            if (wr_a) begin got_w.push_back(wdata_a); got_t.push_back(1'b0); end
            if (wr_b) begin got_w.push_back(wdata_b); got_t.push_back(1'b1); end
        end
    end

    task automatic drive(logic c, logic [DW-1:0] d);
        cmd_pin = c;
        din = d;
        @(negedge clk);
    endtask

    // Independent thread bookkeeping for bursts
    logic s_thr = 1'b0;
    int   s_cnt = 0;

    task automatic burst(int n, logic [DW-1:0] seed, int pre);
        logic [DW-1:0] words[$];
        logic          texp[$];
        logic          t;
        int            c;
        t = s_thr;
        c = s_cnt;
        for (int k = 0; k < n; k++) begin
            words.push_back(seed + DW'(k) * 32'h0101_0107);
            if (c == CAP) begin t = ~t; c = 0; end
            c++;
            texp.push_back(t);
        end
        if (c == CAP) begin s_thr = ~t; s_cnt = 0; end
        else begin s_thr = t; s_cnt = c; end
        got_w.delete();
        got_t.delete();
        for (int k = 0; k < pre; k++) drive(1'b1, '0);
        drive(1'b0, '0);
        drive(1'b0, words[0]);
        for (int k = 1; k < n; k++) drive(1'b1, words[k]);
        drive(1'b0, 32'hDEAD_BEEF);
        drive(1'b0, '0);
        drive(1'b0, '0);
        chk("R5 word count", DW'(got_w.size()), DW'(n));
        for (int k = 0; k < n; k++) begin
            if (k < got_w.size()) begin
                chk(k == 0 ? "R2 first word" : "R7 word order", got_w[k], words[k]);
                chk("R6 thread of word", {31'b0, got_t[k]}, {31'b0, texp[k]});
            end
        end
        chk("R8 idle thread", {31'b0, cur_thr}, {31'b0, s_thr});
    endtask

    initial begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk("R1 wr_a in reset", {31'b0, wr_a}, '0);
        chk("R1 wr_b in reset", {31'b0, wr_b}, '0);
        chk("R1 wdata_a in reset", wdata_a, '0);
        chk("R1 cur_thr in reset", {31'b0, cur_thr}, '0);
        rst = 1'b0;
        drive(1'b0, '0);
        drive(1'b0, '0);
        burst(3, 32'h1000_0001, 1);   // partial A
        burst(2, 32'h2000_0001, 1);   // fills A exactly -> idle B
        burst(7, 32'h3000_0001, 1);   // B full, switch to A
        burst(1, 32'h4000_0001, 1);   // single word, continue A
        burst(12, 32'h5000_0001, 1);  // two switches, ends exactly full
        burst(4, 32'h6000_0001, 3);   // R2 extended high prefix
        // R9 abandoned sequence: high, low, high
        got_w.delete();
        drive(1'b1, '0);
        drive(1'b0, 32'hAAAA_0001);
        drive(1'b1, 32'hAAAA_0002);
        drive(1'b0, '0);
        drive(1'b0, '0);
        chk("R9 no write on abort", DW'(got_w.size()), '0);
        chk("R9 idle thread kept", {31'b0, cur_thr}, {31'b0, s_thr});
        burst(6, 32'h7000_0001, 1);
        burst(5, 32'h8000_0001, 2);
        repeat (4) drive(1'b0, '0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL R7 watchdog expired: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule